// File: doc/BRIEF.md
# Linked-Descriptor Word Copy Engine

This block is the transfer engine of a single DMA channel. A start pulse gives it the address of a first descriptor. It then walks a chain of descriptors held in memory. Each descriptor is six 32-bit words. The engine reads all six words, then copies 32-bit words from a source address to a destination address. It repeats this for a number of rows and moves on to the descriptor named by the link word. A link of zero ends the chain.

Copies run in one of two modes. In linear mode a single run of bytes is copied. In 2D mode several rows are copied, and a signed per-row offset is applied to each address between rows. Per-descriptor flags decide three things: whether each address steps forward, whether reads are skipped (the data is then zero), and whether writes are dropped. The descriptor fields stay visible on outputs while the engine runs, and the remaining length is updated after every word. Three one-cycle events are produced: descriptor finished, interrupt, and chain stopped.

All memory traffic uses one master port. The port has one access outstanding at a time, handshaked by request and acknowledge. Register decode and arbitration between channels sit outside this block.

Top module: `cb_dma_engine`

## Requirements
- R1: In the idle state, a start pulse with the channel enable high latches the descriptor address onto `cur_cb_o`, sets `active_o` and clears `paused_o`. A start pulse while `active_o` is high is ignored.
- R2: A start pulse while the channel enable is low is ignored: no memory request is made and `active_o` stays low.
- R3: A descriptor is fetched as six word reads at byte offsets +0 to +20 from its address, in this order: control word, source address, destination address, length, stride, link. These fields then appear on the `cur_*` outputs.
- R4: Each word transfer reads from the source and then writes that data to the destination. The source address advances by 4 only when control bit 8 is set; the destination address advances by 4 only when control bit 4 is set. The remaining byte count X drops by 4 per word, and a remainder below 4 still costs one full word.
- R5: Control bit 11 set means no read is issued and the data written is zero. Control bit 7 set means no write is issued.
- R6: Control bit 1 selects 2D mode. In 2D mode, length bits [15:0] are X in bytes and bits [29:16] are the row count Y. Stride bits [31:16] are a signed destination offset and bits [15:0] a signed source offset, each added to its address after every row except the last. In linear mode, Y is 1, X is the whole length word, and both offsets are zero.
- R7: After each word, `cur_len_o` shows what remains. In 2D mode this is (Y << 16) | X, where Y counts the rows left including the current row. In linear mode it is X.
- R8: When a descriptor finishes, `blk_end_o` pulses for one cycle. `irq_o` pulses in the same cycle when control bit 0 is set.
- R9: After a descriptor, its link becomes `cur_cb_o`. The chain stops when that address is zero or the channel enable is low. On stopping, `done_o` pulses, `active_o` clears, `paused_o` sets, and no further fetch is made. A start address of zero stops without any fetch.
- R10: A 2D descriptor with Y equal to 0 finishes with no word transfers.
- R11: Once raised, `mem_req_o` stays high with `mem_addr_o`, `mem_we_o` and `mem_wdata_o` unchanged until the cycle in which `mem_ack_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| chan_en_i | input | 1 | Channel enable |
| cb_addr_i | input | AW | First descriptor address |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with ack |
| mem_ack_i | input | 1 | Access completes |
| cur_cb_o | output | AW | Current descriptor address |
| cur_info_o | output | DW | Control word |
| cur_src_o | output | AW | Live source address |
| cur_dst_o | output | AW | Live destination address |
| cur_len_o | output | DW | Live remaining length |
| cur_stride_o | output | DW | Stride word |
| cur_next_o | output | AW | Link word |
| active_o | output | 1 | Engine busy |
| paused_o | output | 1 | Engine stopped after a run |
| blk_end_o | output | 1 | Descriptor finished pulse |
| irq_o | output | 1 | Interrupt pulse |
| done_o | output | 1 | Chain stopped pulse |

## Verification
The bench looks at the places where the walk can go quietly wrong:
- A negative source offset on a 2D copy catches a design that zero-extends the stride; it would jump forward in memory.
- The final value of 0x0001_0000 in `cur_len_o` catches a design that decrements the row count before the write-back.
- A zero-row 2D descriptor catches an engine that underflows Y and copies forever.
- An odd byte count catches a design whose X wraps instead of stopping.
- Chains that mix read-skip and write-drop descriptors catch a design that issues a read whose data is unused, or writes stale data.
- Dropping the enable in mid-chain must stop the engine with the link address latched and no further fetch.
- A second start while busy must change nothing, or the scoreboard sees accesses it did not expect.

// File: rtl/dma_cb_pkg.sv
package dma_cb_pkg;

   localparam int unsigned DESC_WORDS  = 6;
   localparam int unsigned WORD_BYTES  = 4;
   localparam int unsigned ROW_W       = 14;
   localparam int unsigned OFS_W       = 16;

   // control word bit positions
   localparam int unsigned CTL_IRQ_EN  = 0;
   localparam int unsigned CTL_TWO_D   = 1;
   localparam int unsigned CTL_DST_INC = 4;
   localparam int unsigned CTL_DST_IGN = 7;
   localparam int unsigned CTL_SRC_INC = 8;
   localparam int unsigned CTL_SRC_IGN = 11;

   // descriptor word slots
   localparam int unsigned SLOT_CTL    = 0;
   localparam int unsigned SLOT_SRC    = 1;
   localparam int unsigned SLOT_DST    = 2;
   localparam int unsigned SLOT_LEN    = 3;
   localparam int unsigned SLOT_STRIDE = 4;
   localparam int unsigned SLOT_LINK   = 5;

   typedef enum logic [3:0] {
      WK_IDLE,
      WK_CHECK,
      WK_FETCH,
      WK_LOAD,
      WK_READ,
      WK_WRITE,
      WK_ROW,
      WK_BLOCK,
      WK_STOP
   } walk_state_t;

endpackage

// File: rtl/dma_cb_geom.sv
module dma_cb_geom
   import dma_cb_pkg::*;
#(
   parameter int DW         = 32,
   parameter bit SUPPORT_2D = 1'b1
) (
   input  logic [DW-1:0]    ctl_i,
   input  logic [DW-1:0]    len_i,
   input  logic [DW-1:0]    stride_i,
   output logic             two_d_o,
   output logic [DW-1:0]    x_bytes_o,
   output logic [ROW_W-1:0] y_rows_o,
   output logic [OFS_W-1:0] src_ofs_o,
   output logic [OFS_W-1:0] dst_ofs_o
);

   initial begin
      assert_geom_width_R6: assert (DW == 32)
         else $error("dma_cb_geom: DW must be 32");
   end

   generate
      if (SUPPORT_2D) begin : g_two_d
         assign two_d_o = ctl_i[CTL_TWO_D];
      end else begin : g_linear_only
         assign two_d_o = 1'b0;
      end
   endgenerate

   always_comb begin
      if (two_d_o) begin
         x_bytes_o = {{(DW-16){1'b0}}, len_i[15:0]};
         y_rows_o  = len_i[16 +: ROW_W];
         src_ofs_o = stride_i[15:0];
         dst_ofs_o = stride_i[31:16];
      end else begin
         x_bytes_o = len_i;
         y_rows_o  = ROW_W'(1);
         src_ofs_o = '0;
         dst_ofs_o = '0;
      end
   end

   logic unused_geom;
   assign unused_geom = ^{ctl_i[DW-1:CTL_TWO_D+1], ctl_i[0], len_i[DW-1:30]};

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
   import dma_cb_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [AW-1:0]    addr_i,
   input  logic             inc_en_i,
   input  logic             beat_i,
   input  logic             row_i,
   input  logic [OFS_W-1:0] ofs_i,
   output logic [AW-1:0]    addr_o
);

   localparam int EXT_W = AW - OFS_W;

   initial begin
      assert_step_width_R6: assert (AW > OFS_W && AW <= 32)
         else $error("dma_addr_step: AW out of range");
   end

   logic [AW-1:0] ofs_ext;
   assign ofs_ext = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};

   always_comb begin
      if (row_i)
         addr_o = addr_i + ofs_ext;
      else if (beat_i && inc_en_i)
         addr_o = addr_i + AW'(WORD_BYTES);
      else
         addr_o = addr_i;
   end

endmodule

// File: rtl/cb_dma_engine.sv
module cb_dma_engine
   import dma_cb_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter bit SUPPORT_2D = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          chan_en_i,
   input  logic [AW-1:0] cb_addr_i,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic [DW-1:0] mem_rdata_i,
   input  logic          mem_ack_i,
   output logic [AW-1:0] cur_cb_o,
   output logic [DW-1:0] cur_info_o,
   output logic [AW-1:0] cur_src_o,
   output logic [AW-1:0] cur_dst_o,
   output logic [DW-1:0] cur_len_o,
   output logic [DW-1:0] cur_stride_o,
   output logic [AW-1:0] cur_next_o,
   output logic          active_o,
   output logic          paused_o,
   output logic          blk_end_o,
   output logic          irq_o,
   output logic          done_o
);

   localparam int IDX_W = $clog2(DESC_WORDS);

   initial begin
      assert_top_params_R3: assert (DW == 32 && AW > OFS_W && AW <= DW)
         else $error("cb_dma_engine: unsupported widths");
   end

   walk_state_t       state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [AW-1:0]     cb_q;
   logic [DW-1:0]     desc_q [DESC_WORDS];
   logic [AW-1:0]     src_q, dst_q;
   logic [DW-1:0]     len_q, x_rem_q, data_q;
   logic [ROW_W-1:0]  y_rem_q;
   logic              active_q, paused_q;

   // descriptor geometry
   logic              two_d;
   logic [DW-1:0]     x_init;
   logic [ROW_W-1:0]  y_init;
   logic [OFS_W-1:0]  src_ofs, dst_ofs;

   dma_cb_geom #(.DW(DW), .SUPPORT_2D(SUPPORT_2D)) u_geom (
      .ctl_i     (desc_q[SLOT_CTL]),
      .len_i     (desc_q[SLOT_LEN]),
      .stride_i  (desc_q[SLOT_STRIDE]),
      .two_d_o   (two_d),
      .x_bytes_o (x_init),
      .y_rows_o  (y_init),
      .src_ofs_o (src_ofs),
      .dst_ofs_o (dst_ofs)
   );

   logic src_ign, dst_ign;
   assign src_ign = desc_q[SLOT_CTL][CTL_SRC_IGN];
   assign dst_ign = desc_q[SLOT_CTL][CTL_DST_IGN];

   // handshake decode
   logic fetch_ack, read_done, beat_done, row_adv;
   assign fetch_ack = (state_q == WK_FETCH) && mem_ack_i;
   assign read_done = (state_q == WK_READ) && (src_ign || mem_ack_i);
   assign beat_done = (state_q == WK_WRITE) && (dst_ign || mem_ack_i);
   assign row_adv   = (state_q == WK_ROW) && (y_rem_q != ROW_W'(1));

   logic [DW-1:0] x_next;
   assign x_next = (x_rem_q > DW'(WORD_BYTES)) ? x_rem_q - DW'(WORD_BYTES) : '0;

   // address stepping
   logic [AW-1:0] src_step, dst_step;

   dma_addr_step #(.AW(AW)) u_src_step (
      .addr_i   (src_q),
      .inc_en_i (desc_q[SLOT_CTL][CTL_SRC_INC]),
      .beat_i   (beat_done),
      .row_i    (row_adv),
      .ofs_i    (src_ofs),
      .addr_o   (src_step)
   );

   dma_addr_step #(.AW(AW)) u_dst_step (
      .addr_i   (dst_q),
      .inc_en_i (desc_q[SLOT_CTL][CTL_DST_INC]),
      .beat_i   (beat_done),
      .row_i    (row_adv),
      .ofs_i    (dst_ofs),
      .addr_o   (dst_step)
   );

   // descriptor word capture
   generate
      for (genvar g = 0; g < DESC_WORDS; g++) begin : g_desc
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               desc_q[g] <= '0;
            else if (fetch_ack && idx_q == IDX_W'(g))
               desc_q[g] <= mem_rdata_i;
         end
      end
   endgenerate

   // walker
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= WK_IDLE;
         idx_q    <= '0;
         cb_q     <= '0;
         src_q    <= '0;
         dst_q    <= '0;
         len_q    <= '0;
         x_rem_q  <= '0;
         y_rem_q  <= '0;
         data_q   <= '0;
         active_q <= 1'b0;
         paused_q <= 1'b0;
      end else begin
         unique case (state_q)
            WK_IDLE: begin
               if (start_i && chan_en_i) begin
                  cb_q     <= cb_addr_i;
                  active_q <= 1'b1;
                  paused_q <= 1'b0;
                  state_q  <= WK_CHECK;
               end
            end
            WK_CHECK: begin
               idx_q <= '0;
               if (cb_q == '0 || !chan_en_i)
                  state_q <= WK_STOP;
               else
                  state_q <= WK_FETCH;
            end
            WK_FETCH: begin
               if (mem_ack_i) begin
                  if (idx_q == IDX_W'(DESC_WORDS - 1))
                     state_q <= WK_LOAD;
                  else
                     idx_q <= idx_q + IDX_W'(1);
               end
            end
            WK_LOAD: begin
               src_q   <= desc_q[SLOT_SRC][AW-1:0];
               dst_q   <= desc_q[SLOT_DST][AW-1:0];
               len_q   <= desc_q[SLOT_LEN];
               x_rem_q <= x_init;
               y_rem_q <= y_init;
               if (y_init == '0)
                  state_q <= WK_BLOCK;
               else if (x_init == '0)
                  state_q <= WK_ROW;
               else
                  state_q <= WK_READ;
            end
            WK_READ: begin
               if (read_done) begin
                  data_q  <= src_ign ? '0 : mem_rdata_i;
                  state_q <= WK_WRITE;
               end
            end
            WK_WRITE: begin
               if (beat_done) begin
                  src_q   <= src_step;
                  dst_q   <= dst_step;
                  x_rem_q <= x_next;
                  len_q   <= two_d ? {2'b00, y_rem_q, x_next[15:0]} : x_next;
                  state_q <= (x_next == '0) ? WK_ROW : WK_READ;
               end
            end
            WK_ROW: begin
               if (y_rem_q == ROW_W'(1)) begin
                  state_q <= WK_BLOCK;
               end else begin
                  src_q   <= src_step;
                  dst_q   <= dst_step;
                  y_rem_q <= y_rem_q - ROW_W'(1);
                  x_rem_q <= x_init;
                  state_q <= (x_init == '0) ? WK_ROW : WK_READ;
               end
            end
            WK_BLOCK: begin
               cb_q    <= desc_q[SLOT_LINK][AW-1:0];
               state_q <= WK_CHECK;
            end
            WK_STOP: begin
               active_q <= 1'b0;
               paused_q <= 1'b1;
               state_q  <= WK_IDLE;
            end
            default: state_q <= WK_IDLE;
         endcase
      end
   end

   // memory port
   always_comb begin
      mem_req_o  = 1'b0;
      mem_we_o   = 1'b0;
      mem_addr_o = dst_q;
      unique case (state_q)
         WK_FETCH: begin
            mem_req_o  = 1'b1;
            mem_addr_o = cb_q + AW'({idx_q, 2'b00});
         end
         WK_READ: begin
            mem_req_o  = !src_ign;
            mem_addr_o = src_q;
         end
         WK_WRITE: begin
            mem_req_o  = !dst_ign;
            mem_we_o   = 1'b1;
         end
         default: ;
      endcase
   end
   assign mem_wdata_o = data_q;

   assign cur_cb_o     = cb_q;
   assign cur_info_o   = desc_q[SLOT_CTL];
   assign cur_src_o    = src_q;
   assign cur_dst_o    = dst_q;
   assign cur_len_o    = len_q;
   assign cur_stride_o = desc_q[SLOT_STRIDE];
   assign cur_next_o   = desc_q[SLOT_LINK][AW-1:0];
   assign active_o     = active_q;
   assign paused_o     = paused_q;
   assign blk_end_o    = (state_q == WK_BLOCK);
   assign irq_o        = (state_q == WK_BLOCK) && desc_q[SLOT_CTL][CTL_IRQ_EN];
   assign done_o       = (state_q == WK_STOP);

   logic unused_top;
   assign unused_top = ^{desc_q[SLOT_SRC], desc_q[SLOT_DST], desc_q[SLOT_LINK]};

   // checks on the port and state
   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                  && $stable(mem_we_o) && $stable(mem_wdata_o));

   assert_req_while_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> active_o);

   assert_no_dropped_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && mem_we_o |-> !cur_info_o[CTL_DST_IGN]);

   assert_stop_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !active_o && paused_o);

   assert_busy_start_keeps_cb_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && active_o && !blk_end_o |=> $stable(cur_cb_o));

endmodule

// File: tb/cb_dma_engine_test.sv
module cb_dma_engine_test;

   localparam int AW = 32;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          chan_en_i = 1'b1;
   logic [AW-1:0] cb_addr_i = '0;
   logic          mem_req_o, mem_we_o;
   logic [AW-1:0] mem_addr_o;
   logic [DW-1:0] mem_wdata_o;
   logic [DW-1:0] mem_rdata_i = '0;
   logic          mem_ack_i = 1'b0;
   logic [AW-1:0] cur_cb_o, cur_src_o, cur_dst_o, cur_next_o;
   logic [DW-1:0] cur_info_o, cur_len_o, cur_stride_o;
   logic          active_o, paused_o, blk_end_o, irq_o, done_o;

   always #5 clk = ~clk;

   cb_dma_engine #(.AW(AW), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_en_i(chan_en_i),
      .cb_addr_i(cb_addr_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
      .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
      .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
      .cur_cb_o(cur_cb_o), .cur_info_o(cur_info_o), .cur_src_o(cur_src_o),
      .cur_dst_o(cur_dst_o), .cur_len_o(cur_len_o), .cur_stride_o(cur_stride_o),
      .cur_next_o(cur_next_o), .active_o(active_o), .paused_o(paused_o),
      .blk_end_o(blk_end_o), .irq_o(irq_o), .done_o(done_o)
   );

   typedef struct packed {
      logic [31:0] a;
      logic        we;
      logic [31:0] d;
   } acc_t;

   logic [31:0] mem   [256];
   logic [31:0] model [256];
   acc_t        exp_q [$];
   int          n_checks = 0;
   int          n_fail   = 0;
   int          n_blk = 0, n_irq = 0, n_done = 0;
   bit          finished = 1'b0;

   task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory responder and scoreboard monitor
   int lat_cnt = 0;
   int lat_sel = 0;
   always @(negedge clk) begin
      if (mem_ack_i) begin
         mem_ack_i = 1'b0;
      end else if (rst_n && mem_req_o) begin
         if (lat_cnt >= lat_sel) begin
            acc_t e;
            lat_cnt = 0;
            lat_sel = (lat_sel + 1) % 3;
            n_checks++;
            if (exp_q.size() == 0) begin
               n_fail++;
               $display("FAIL R2/R9 unexpected access actual=%h we=%0d expected=none",
                        mem_addr_o, mem_we_o);
            end else begin
               e = exp_q.pop_front();
               if (e.a !== mem_addr_o || e.we !== mem_we_o ||
                   (e.we && e.d !== mem_wdata_o)) begin
                  n_fail++;
                  $display("FAIL R3/R4/R5 access actual=%h/%0d/%h expected=%h/%0d/%h",
                           mem_addr_o, mem_we_o, mem_wdata_o, e.a, e.we, e.d);
               end
            end
            if (mem_we_o) mem[mem_addr_o[9:2]] = mem_wdata_o;
            else          mem_rdata_i = mem[mem_addr_o[9:2]];
            mem_ack_i = 1'b1;
         end else begin
            lat_cnt++;
         end
      end
   end

   always @(negedge clk) begin
      if (blk_end_o) n_blk++;
      if (irq_o)     n_irq++;
      if (done_o)    n_done++;
   end

   task automatic put(input logic [31:0] a, input logic [31:0] v);
      mem[a[9:2]]   = v;
      model[a[9:2]] = v;
   endtask

   task automatic desc(input logic [31:0] cb, input logic [31:0] ctl, input logic [31:0] s,
                       input logic [31:0] d, input logic [31:0] len,
                       input logic [31:0] str, input logic [31:0] nxt);
      put(cb, ctl); put(cb + 4, s); put(cb + 8, d);
      put(cb + 12, len); put(cb + 16, str); put(cb + 20, nxt);
   endtask

   function automatic logic [31:0] sx(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   // expected accesses, built from the requirements
   task automatic model_chain(input logic [31:0] cb0, input int maxblk);
      logic [31:0] cb, w [6], s, d, x, xx, ss, ds, data;
      logic [13:0] y;
      int blk;
      cb  = cb0;
      blk = 0;
      while (cb != 0 && blk < maxblk) begin
         for (int k = 0; k < 6; k++) begin
            exp_q.push_back('{a: cb + 4 * k, we: 1'b0, d: '0});
            w[k] = model[(cb[9:2] + k) & 8'hff];
         end
         if (w[0][1]) begin
            x = {16'h0, w[3][15:0]}; y = w[3][29:16];
            ss = sx(w[4][15:0]);     ds = sx(w[4][31:16]);
         end else begin
            x = w[3]; y = 14'd1; ss = 0; ds = 0;
         end
         s = w[1];
         d = w[2];
         while (y != 0) begin
            xx = x;
            while (xx != 0) begin
               if (w[0][11]) data = 0;
               else begin
                  data = model[s[9:2]];
                  exp_q.push_back('{a: s, we: 1'b0, d: '0});
               end
               if (w[0][8]) s = s + 4;
               if (!w[0][7]) begin
                  exp_q.push_back('{a: d, we: 1'b1, d: data});
                  model[d[9:2]] = data;
               end
               if (w[0][4]) d = d + 4;
               xx = (xx > 4) ? xx - 4 : 0;
            end
            y = y - 1;
            if (y != 0) begin
               s = s + ss;
               d = d + ds;
            end
         end
         cb = w[5];
         blk++;
      end
   endtask

   task automatic pulse_start(input logic [31:0] cb);
      @(negedge clk);
      cb_addr_i = cb;
      start_i   = 1'b1;
      @(negedge clk);
      start_i   = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      int t;
      t = 0;
      while (!done_o && t < 4000) begin
         @(negedge clk);
         t++;
      end
      check32({tag, " stop seen"}, {31'd0, done_o}, 32'd1);
      @(negedge clk);
      check32({tag, " active low after stop"}, {31'd0, active_o}, 32'd0);
      check32({tag, " paused after stop"}, {31'd0, paused_o}, 32'd1);
      check32({tag, " scoreboard drained"}, exp_q.size(), 32'd0);
   endtask

   initial begin
      #1500000;
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int b_blk, b_irq, b_done;
      for (int i = 0; i < 256; i++) put(i * 4, 32'hA500_0000 + i);

      repeat (3) @(negedge clk);
      // R1 reset state
      check32("R1 reset active", {31'd0, active_o}, 32'd0);
      check32("R9 reset paused", {31'd0, paused_o}, 32'd0);
      check32("R11 reset req", {31'd0, mem_req_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // T1 linear copy, both increments, interrupt enabled (R3 R4 R8)
      desc(32'h040, 32'h0000_0111, 32'h100, 32'h180, 32'd12, 32'h0, 32'h0);
      b_blk = n_blk; b_irq = n_irq;
      model_chain(32'h040, 16);
      pulse_start(32'h040);
      check32("R1 active after start", {31'd0, active_o}, 32'd1);
      wait_done("R4 linear");
      check32("R4 src advanced", cur_src_o, 32'h10C);
      check32("R4 dst advanced", cur_dst_o, 32'h18C);
      check32("R7 linear len zero", cur_len_o, 32'd0);
      check32("R3 info visible", cur_info_o, 32'h0000_0111);
      check32("R8 one block end", n_blk - b_blk, 32'd1);
      check32("R8 irq raised", n_irq - b_irq, 32'd1);
      check32("R4 copied word", mem[32'h188 >> 2], 32'hA500_0000 + (32'h108 >> 2));

      // T2 chain: plain copy -> zero fill -> read only (R5 R9)
      desc(32'h060, 32'h0000_0110, 32'h120, 32'h1A0, 32'd8, 32'h0, 32'h078);
      desc(32'h078, 32'h0000_0811, 32'h0,   32'h1C0, 32'd8, 32'h0, 32'h090);
      desc(32'h090, 32'h0000_0190, 32'h140, 32'h1E0, 32'd8, 32'h0, 32'h0);
      b_blk = n_blk; b_irq = n_irq;
      model_chain(32'h060, 16);
      pulse_start(32'h060);
      wait_done("R9 chain");
      check32("R9 three blocks", n_blk - b_blk, 32'd3);
      check32("R8 irq only on flagged block", n_irq - b_irq, 32'd1);
      check32("R5 zero fill", mem[32'h1C4 >> 2], 32'h0);
      check32("R5 write dropped", mem[32'h1E0 >> 2], 32'hA500_0000 + (32'h1E0 >> 2));
      check32("R9 link zero at end", cur_cb_o, 32'h0);

      // T3 2D with negative source offset (R6 R7)
      desc(32'h0B0, 32'h0000_0112, 32'h200, 32'h300, 32'h0003_0008, 32'h0008_FFF0, 32'h0);
      model_chain(32'h0B0, 16);
      pulse_start(32'h0B0);
      wait_done("R6 2D");
      check32("R6 src after rows", cur_src_o, 32'h1F8);
      check32("R6 dst after rows", cur_dst_o, 32'h328);
      check32("R7 2D length field", cur_len_o, 32'h0001_0000);
      check32("R3 stride visible", cur_stride_o, 32'h0008_FFF0);

      // T4 2D with zero rows (R10)
      desc(32'h0D0, 32'h0000_0112, 32'h220, 32'h340, 32'h0000_0008, 32'h0, 32'h0);
      b_blk = n_blk;
      model_chain(32'h0D0, 16);
      pulse_start(32'h0D0);
      wait_done("R10 zero rows");
      check32("R10 block ended", n_blk - b_blk, 32'd1);
      check32("R10 src untouched", cur_src_o, 32'h220);
      check32("R10 len untouched", cur_len_o, 32'h8);

      // T5 odd byte count, no increments (R4)
      desc(32'h0E8, 32'h0000_0000, 32'h230, 32'h350, 32'd6, 32'h0, 32'h0);
      model_chain(32'h0E8, 16);
      pulse_start(32'h0E8);
      wait_done("R4 odd count");
      check32("R4 src fixed", cur_src_o, 32'h230);
      check32("R4 len clamps to zero", cur_len_o, 32'h0);

      // T6 start with enable low (R2)
      b_done = n_done;
      chan_en_i = 1'b0;
      pulse_start(32'h040);
      repeat (20) @(negedge clk);
      check32("R2 stays inactive", {31'd0, active_o}, 32'd0);
      check32("R2 no stop event", n_done - b_done, 32'd0);
      chan_en_i = 1'b1;

      // T7 start address zero (R9)
      b_done = n_done;
      pulse_start(32'h0);
      wait_done("R9 zero start");
      check32("R9 zero start stop event", n_done - b_done, 32'd1);

      // T8 start while busy is ignored (R1)
      desc(32'h100 + 32'h200, 32'h0000_0110, 32'h240, 32'h360, 32'd16, 32'h0, 32'h0);
      model_chain(32'h300, 16);
      pulse_start(32'h300);
      repeat (3) @(negedge clk);
      pulse_start(32'h040);
      check32("R1 busy start keeps address", cur_cb_o, 32'h300);
      wait_done("R1 busy start");

      // T9 enable dropped mid chain (R9)
      desc(32'h318, 32'h0000_0110, 32'h250, 32'h370, 32'd16, 32'h0, 32'h330);
      desc(32'h330, 32'h0000_0110, 32'h260, 32'h380, 32'd16, 32'h0, 32'h0);
      b_blk = n_blk;
      model_chain(32'h318, 1);
      pulse_start(32'h318);
      repeat (4) @(negedge clk);
      chan_en_i = 1'b0;
      wait_done("R9 enable drop");
      check32("R9 link latched", cur_cb_o, 32'h330);
      check32("R9 single block", n_blk - b_blk, 32'd1);
      chan_en_i = 1'b1;

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule